// File: doc/BRIEF.md
# DMA Channel Start and Mode Control

This block holds the mode settings of a two-channel DMA engine that moves data between peripheral registers and internal RAM, and it decides when each channel starts a transfer. Every channel owns an 8-bit mode byte. The byte selects the direction and the width of the transfer. It holds a hold bit that can park start requests. It holds a 4-bit field that picks one of fifteen hardware request lines. It also has a write-only bit that fires one transfer from software.

The CPU side writes a whole byte or a single bit of either channel's byte and reads the byte back combinationally. The engine side supplies a per-channel enable, a per-channel busy flag and a done pulse from channel 0. For each transfer the block returns one registered start pulse, together with that channel's direction and width. When both channels want to start in the same cycle, channel 0 goes first and channel 1 waits for channel 0's done.

Top module: `dma_start_ctrl`

## Requirements
- R1: After reset both mode bytes read 0x00 and no start pulse is issued.
- R2: Bit 7 of a mode byte always reads 0. Writing 1 to it, by byte write or by single-bit write, gives exactly one start pulse on the next cycle, but only while that channel's enable is 1.
- R3: The software trigger of R2 starts a transfer whatever value the source field (bits 3..0) holds, including 0.
- R4: start_dir carries bit 6 (0 = peripheral register to RAM, 1 = RAM to peripheral register) and start_wide carries bit 5 (0 = 8-bit, 1 = 16-bit). Both are taken as the byte stood in the cycle the start was decided.
- R5: While the hold (bit 4) is in effect, requests are stored rather than issued. Clearing bit 4 releases a stored request, whose start pulse follows one cycle after the cleared value is stored.
- R6: A hold takes effect only once bit 4 has read 1 for two full cycles. Requests arriving before that still issue.
- R7: While a channel's busy flag is 1, writes to its bits 6, 5 and 3..0 are ignored. Bits 4 and 7 still act.
- R8: A single-bit write (wr_bit = 1) sets bit wr_idx to wr_data[0] and leaves every other bit of the byte unchanged.
- R9: A hardware request is taken when the source field is nonzero, the request line with that index is 1, and the channel is enabled. Each such cycle counts as one request. A source value of 0 selects no line.
- R10: A channel stores at most one held request. Any number of requests during a hold release as one start.
- R11: Both channels never start in the same cycle. On a same-cycle contest channel 0 starts, and channel 1 starts on the first cycle after a channel-0 done in which channel 0 is not also starting.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 1 | Channel addressed by the write |
| wr_bit | input | 1 | 1 = single-bit write, 0 = byte write |
| wr_idx | input | 3 | Bit index for a single-bit write |
| wr_data | input | 8 | Byte to write; bit 0 is the value in a single-bit write |
| rd_ch | input | 1 | Channel whose byte appears on rd_data |
| rd_data | output | 8 | Mode byte of channel rd_ch, bit 7 reads 0 |
| hw_req | input | 16 | Hardware request lines, index 0 unused |
| ch_en | input | 2 | Per-channel enable |
| ch_busy | input | 2 | Per-channel transfer-in-progress flag |
| ch0_done | input | 1 | One-cycle pulse when channel 0 finishes a transfer |
| start_o | output | 2 | One-cycle start pulse per channel |
| start_dir | output | 2 | Direction of the starting channel |
| start_wide | output | 2 | Width of the starting channel |

## Verification
The assertions assume that ch0_done comes only as a single-cycle pulse after a channel-0 start. They also assume that busy and enable change only between clock edges and never while reset is active. The bench drives ch0_done from a stub that waits a fixed number of cycles after each observed channel-0 start. All inputs change one time unit after a falling edge, and hardware lines are pulsed for one cycle at a time, so each pulse counts as one request.

// File: rtl/dma_start_ctrl.sv
module dma_start_ctrl #(
  parameter int SRC_W = 4,
  localparam int NREQ = 1 << SRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_ch,
  input  logic             wr_bit,
  input  logic [2:0]       wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             rd_ch,
  output logic [7:0]       rd_data,
  input  logic [NREQ-1:0]  hw_req,
  input  logic [1:0]       ch_en,
  input  logic [1:0]       ch_busy,
  input  logic             ch0_done,
  output logic [1:0]       start_o,
  output logic [1:0]       start_dir,
  output logic [1:0]       start_wide
);

  logic [1:0]       dir_q, wide_q, hold_q, d1_q, d2_q, pend_q;
  logic [SRC_W-1:0] src_q [2];
  logic             wait_q;
  logic [7:0]       cur [2];
  logic [7:0]       nb  [2];
  logic [1:0]       req, blk, want;
  logic             go0, go1, wait_d, grant1;

  always_comb begin
    for (int n = 0; n < 2; n++) begin
      cur[n] = {1'b0, dir_q[n], wide_q[n], hold_q[n], src_q[n]};
      nb[n]  = cur[n];
      if (wr_en && wr_ch == 1'(n)) begin
        if (wr_bit) nb[n][wr_idx] = wr_data[0];
        else        nb[n] = wr_data;
      end
      req[n]  = ch_en[n] & (nb[n][7] | ((src_q[n] != '0) & hw_req[src_q[n]]));
      blk[n]  = hold_q[n] & d1_q[n] & d2_q[n];
      want[n] = ~blk[n] & (req[n] | pend_q[n]);
    end
  end

  assign rd_data = cur[rd_ch];
  assign grant1  = ch0_done & ~want[0];
  assign go0     = want[0];
  assign go1     = wait_q ? grant1 : (want[1] & ~want[0]);
  assign wait_d  = wait_q ? ~grant1 : (want[1] & want[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; wide_q <= '0; hold_q <= '0;
      d1_q <= '0; d2_q <= '0; pend_q <= '0;
      src_q[0] <= '0; src_q[1] <= '0;
      wait_q <= 1'b0;
      start_o <= '0; start_dir <= '0; start_wide <= '0;
    end else begin
      for (int n = 0; n < 2; n++) begin
        pend_q[n] <= blk[n] & (pend_q[n] | req[n]);
        d1_q[n]   <= hold_q[n];
        d2_q[n]   <= d1_q[n];
        hold_q[n] <= nb[n][4];
        if (!ch_busy[n]) begin
          dir_q[n]  <= nb[n][6];
          wide_q[n] <= nb[n][5];
          src_q[n]  <= nb[n][SRC_W-1:0];
        end
      end
      wait_q     <= wait_d;
      start_o    <= {go1, go0};
      start_dir  <= dir_q;
      start_wide <= wide_q;
    end
  end

endmodule

module dma_start_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ch_busy,
  input logic [1:0] start_o,
  input logic [1:0] start_dir,
  input logic [1:0] start_wide,
  input logic [1:0] dir_q,
  input logic [1:0] wide_q,
  input logic [1:0] hold_q,
  input logic [3:0] src0
);
  AST_ONE_CHANNEL_START: assert property (@(posedge clk) disable iff (!rst_n) !(start_o[0] && start_o[1])); // R11
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) ch_busy[0] |=> ({dir_q[0], wide_q[0], src0} == $past({dir_q[0], wide_q[0], src0}))); // R7
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (hold_q[0] && $past(hold_q[0]) && $past(hold_q[0], 2)) |=> !start_o[0]); // R6
  AST_ATTR_MATCH: assert property (@(posedge clk) disable iff (!rst_n) start_o[0] |-> (start_dir[0] == $past(dir_q[0]) && start_wide[0] == $past(wide_q[0]))); // R4
endmodule

bind dma_start_ctrl dma_start_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ch_busy(ch_busy), .start_o(start_o),
  .start_dir(start_dir), .start_wide(start_wide), .dir_q(dir_q),
  .wide_q(wide_q), .hold_q(hold_q), .src0(src_q[0])
);

// File: tb/test_dma_start_ctrl.sv
module test_dma_start_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_ch = 0, wr_bit = 0, rd_ch = 0, ch0_done = 0;
  logic [2:0] wr_idx = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [15:0] hw_req = 0;
  logic [1:0] ch_en = 0, ch_busy = 0, start_o, start_dir, start_wide;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  dma_start_ctrl i_dma_start_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_bit(wr_bit),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_ch(rd_ch), .rd_data(rd_data),
    .hw_req(hw_req), .ch_en(ch_en), .ch_busy(ch_busy), .ch0_done(ch0_done),
    .start_o(start_o), .start_dir(start_dir), .start_wide(start_wide));

  always #10 clk = ~clk;

  // reference model
  int m_dir[2], m_wide[2], m_hold[2], m_age[2], m_pend[2], m_src[2], m_wait;
  int nbv[2], rq[2], bk[2], wt[2], g0, g1;
  logic [1:0] e_start, e_dir, e_wide;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_dir[c] = 0; m_wide[c] = 0; m_hold[c] = 0; m_age[c] = 0; m_pend[c] = 0; m_src[c] = 0;
      end
      m_wait = 0; e_start = 0; e_dir = 0; e_wide = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        nbv[c] = m_dir[c] * 64 + m_wide[c] * 32 + m_hold[c] * 16 + m_src[c];
        if (wr_en && int'(wr_ch) == c) begin
          if (wr_bit) nbv[c] = wr_data[0] ? (nbv[c] | (1 << wr_idx)) : (nbv[c] & ~(1 << wr_idx));
          else nbv[c] = int'(wr_data);
        end
        rq[c] = (ch_en[c] && (((nbv[c] >> 7) & 1) == 1 || (m_src[c] != 0 && hw_req[m_src[c]]))) ? 1 : 0;
        bk[c] = (m_hold[c] == 1 && m_age[c] >= 2) ? 1 : 0;
        wt[c] = (bk[c] == 0 && (rq[c] == 1 || m_pend[c] == 1)) ? 1 : 0;
      end
      g0 = wt[0];
      if (m_wait == 1) begin
        g1 = (ch0_done && wt[0] == 0) ? 1 : 0;
        m_wait = g1 ? 0 : 1;
      end else begin
        g1 = (wt[1] == 1 && wt[0] == 0) ? 1 : 0;
        m_wait = (wt[1] == 1 && wt[0] == 1) ? 1 : 0;
      end
      e_start = {g1[0], g0[0]};
      for (int c = 0; c < 2; c++) begin
        e_dir[c] = m_dir[c][0]; e_wide[c] = m_wide[c][0];
        m_pend[c] = (bk[c] == 1 && (m_pend[c] == 1 || rq[c] == 1)) ? 1 : 0;
        m_age[c] = m_hold[c] == 0 ? 0 : (m_age[c] < 2 ? m_age[c] + 1 : 2);
        m_hold[c] = (nbv[c] >> 4) & 1;
        if (!ch_busy[c]) begin
          m_dir[c] = (nbv[c] >> 6) & 1; m_wide[c] = (nbv[c] >> 5) & 1; m_src[c] = nbv[c] & 15;
        end
      end
    end
  end

  function automatic logic [7:0] exp_rd();
    int c = int'(rd_ch);
    return 8'(m_dir[c] * 64 + m_wide[c] * 32 + m_hold[c] * 16 + m_src[c]);
  endfunction

  // compare every cycle away from the active edge
  always @(negedge clk) if (rst_n) begin
    logic [7:0] er;
    er = exp_rd();
    checks++;
    if (rd_data !== er || start_o !== e_start ||
        (e_start[0] && (start_dir[0] !== e_dir[0] || start_wide[0] !== e_wide[0])) ||
        (e_start[1] && (start_dir[1] !== e_dir[1] || start_wide[1] !== e_wide[1]))) begin
      fails++;
      $display("FAIL %s: rd=%h start=%b dir=%b wide=%b, expected rd=%h start=%b dir=%b wide=%b",
               cur_req, rd_data, start_o, start_dir, start_wide, er, e_start, e_dir, e_wide);
    end
  end

  // stub for the transfer engine: done three cycles after a channel 0 start
  int stub_cnt = 0;
  always @(negedge clk) begin
    if (start_o[0]) stub_cnt = 3;
    else if (stub_cnt > 0) stub_cnt--;
    ch0_done <= (stub_cnt == 1);
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      wr_en = 0; hw_req = 0;
    end
  endtask
  task automatic wfull(input logic ch, input logic [7:0] d);
    wr_en = 1; wr_ch = ch; wr_bit = 0; wr_data = d; rd_ch = ch; tick();
  endtask
  task automatic wbit(input logic ch, input logic [2:0] idx, input logic v);
    wr_en = 1; wr_ch = ch; wr_bit = 1; wr_idx = idx; wr_data = {7'd0, v}; rd_ch = ch; tick();
  endtask
  task automatic pulse(input logic [15:0] m);
    hw_req = m; tick();
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    cur_req = "R1";
    checks++;
    if (rd_data !== 8'h00 || start_o !== 2'b00) begin
      fails++; $display("FAIL R1: rd=%h start=%b expected 00 00", rd_data, start_o);
    end
    tick(2);
    cur_req = "R2"; wfull(0, 8'h80); tick(2);
    ch_en = 2'b11; wfull(0, 8'h80); tick(2); wbit(0, 7, 1); tick(2);
    cur_req = "R3"; wfull(0, 8'h85); tick(2); wfull(0, 8'hE0); tick(2);
    cur_req = "R4"; wfull(0, 8'hC0); wfull(0, 8'hA0); wfull(1, 8'hE0); tick(6);
    cur_req = "R8"; wbit(0, 6, 1); wbit(0, 0, 1); wbit(0, 5, 0); wbit(0, 3, 1); tick(2);
    cur_req = "R9"; wfull(0, 8'h05); pulse(16'h0020); pulse(16'h0010); tick();
    ch_en = 2'b10; pulse(16'h0020); ch_en = 2'b11; wfull(0, 8'h00); pulse(16'hFFFF); tick(2);
    cur_req = "R5"; wfull(0, 8'h15); tick(4); pulse(16'h0020); tick(3); wbit(0, 4, 0); tick(3);
    cur_req = "R6"; wbit(0, 4, 1); pulse(16'h0020); pulse(16'h0020); pulse(16'h0020); tick(2);
    wbit(0, 4, 0); tick(2);
    wbit(0, 4, 1); wbit(0, 4, 0); wbit(0, 4, 1); pulse(16'h0020); tick(2); wbit(0, 4, 0); tick(3);
    cur_req = "R10"; wfull(0, 8'h15); tick(3); pulse(16'h0020); wbit(0, 7, 1); pulse(16'h0020);
    tick(2); wfull(0, 8'h05); tick(4);
    cur_req = "R7"; ch_busy = 2'b01; wfull(0, 8'h7F); wbit(0, 6, 0); wbit(0, 2, 0);
    wbit(0, 4, 0); wbit(0, 7, 1); tick(2); ch_busy = 2'b00; wfull(0, 8'h00); tick(2);
    cur_req = "R11"; wfull(0, 8'h43); wfull(1, 8'h23); pulse(16'h0008); tick(10);
    pulse(16'h0008); tick(2); pulse(16'h0008); tick(12);
    wfull(1, 8'h00); pulse(16'h0008); pulse(16'h0008); tick(8);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule